// File: doc/BRIEF.md
# Shared Buffer Mailbox with Per-Slot Semaphores

This block moves data blocks from one producer processor to one consumer processor through a shared storage region held inside the block. The region is split into `NSLOT` slots of `NWORD` words. The producer writes words into a slot, then commits the slot with a word count. Committing sets that slot's semaphore, which the consumer sees as a ready bit and, unless the slot is masked, as an interrupt. The consumer reads the words at any time through a combinational read port. It then releases the slot, and that frees the slot for the producer.

The static parameter `INDEXED` picks one of two modes. With `INDEXED = 1`, every slot carries its own semaphore. The producer can commit several slots before the consumer touches any of them, and the consumer can drain them in any order. With `INDEXED = 0`, the block forms a single-buffer rendezvous. Every slot index is folded onto slot 0, and each transfer takes two synchronisations: a commit that signals the data is present, then a release that raises an acknowledge back to the producer.

Each slot semaphore is a two-state machine. In SLOT_FREE a commit takes the transition *take* to SLOT_HELD, and in SLOT_HELD a release takes the transition *give* back to SLOT_FREE. The rendezvous sequencer has three states. RDV_IDLE goes to RDV_LOADED on *load* (accepted commit). RDV_LOADED goes to RDV_ACKED on *drain* (accepted release). RDV_ACKED goes to RDV_LOADED on *load*, or to RDV_IDLE on *fill* (an accepted word write).

Top module: `mbox_shared`

## Requirements
- R1: A synchronous reset clears every semaphore, the acknowledge and both error flags: `slot_ready` = 0, `irq` = 0, `ack` = 0, `err_ovf` = 0, `err_unf` = 0.
- R2: A commit to a free slot sets bit `commit_slot` of `slot_ready` at the next clock edge. It also latches `commit_cnt` as that slot's word count, clamped to `NWORD` when it is larger. The count is then visible on `rd_cnt` when `rd_slot` selects the slot.
- R3: A word write or a commit aimed at a held slot is rejected. The slot's data and count do not change, and `err_ovf` is set and stays set until reset.
- R4: A release of a held slot clears its `slot_ready` bit at that clock edge. A release of a free slot changes nothing and sets the sticky flag `err_unf`.
- R5: In indexed mode several slots can be held at once, and the consumer can read and release them in an order other than the order in which they were committed, with every word intact.
- R6: `irq` is high exactly while at least one slot is held whose bit in `int_mask` is 0 (a mask bit of 1 hides that slot).
- R7: In rendezvous mode every slot index addresses slot 0. After a release, `ack` rises at the same edge. It falls at the producer's next accepted word write or commit. A write or commit while slot 0 is held is rejected as in R3.
- R8: `rd_data` shows, combinationally, the word last stored at (`rd_slot`, `rd_word`).
- R9: If a commit and a release hit the same held slot in the same cycle, the release wins: the slot ends free and `err_ovf` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Producer word write strobe |
| wr_slot | input | $clog2(NSLOT) | Slot of the word write |
| wr_word | input | $clog2(NWORD) | Word index inside the slot |
| wr_data | input | DW | Word to store |
| commit | input | 1 | Producer commit strobe |
| commit_slot | input | $clog2(NSLOT) | Slot being committed |
| commit_cnt | input | $clog2(NWORD+1) | Valid word count for the commit |
| rel_en | input | 1 | Consumer release strobe |
| rel_slot | input | $clog2(NSLOT) | Slot being released |
| rd_slot | input | $clog2(NSLOT) | Slot of the read port |
| rd_word | input | $clog2(NWORD) | Word index of the read port |
| rd_data | output | DW | Word at the read address |
| rd_cnt | output | $clog2(NWORD+1) | Latched count of the read slot |
| slot_ready | output | NSLOT | Semaphore bits, one per slot |
| int_mask | input | NSLOT | Per-slot interrupt mask, 1 hides the slot |
| irq | output | 1 | Consumer interrupt |
| ack | output | 1 | Rendezvous acknowledge to the producer |
| err_ovf | output | 1 | Sticky flag: a write or commit was aimed at a held slot |
| err_unf | output | 1 | Sticky flag: a release was aimed at a free slot |

## Verification
The bench builds two copies with eight slots of sixteen 32-bit words. One uses `INDEXED = 1` and the other `INDEXED = 0`, so the out-of-order drain and the acknowledge handshake are both reached in the same run. A commit count of 20 on a 16-word slot exercises the clamp. Three slots held at once, with a partly masked interrupt, exercise the per-slot masking. A commit and a release on the same slot in the same cycle cover the collision rule.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef enum logic {
        SLOT_FREE,
        SLOT_HELD
    } slot_st_t;

    typedef enum logic [1:0] {
        RDV_IDLE,
        RDV_LOADED,
        RDV_ACKED
    } rdv_st_t;

endpackage

// File: rtl/mbox_slot.sv
module mbox_slot
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic give,
    output logic held
);

    slot_st_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= SLOT_FREE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: if (take) state_d = SLOT_HELD;
            SLOT_HELD: if (give) state_d = SLOT_FREE;
            default:   state_d = SLOT_FREE;
        endcase
    end

    always_comb begin
        held = (state_q == SLOT_HELD);
    end

    AST_SLOT_STAYS_HELD: assert property (@(posedge clk) disable iff (rst)
        (held && !give) |=> held); // R3
    AST_SLOT_STAYS_FREE: assert property (@(posedge clk) disable iff (rst)
        (!held && !take) |=> !held); // R4

endmodule

// File: rtl/mbox_store.sv
module mbox_store #(
    parameter  int NSLOT = 8,
    parameter  int NWORD = 16,
    parameter  int DW    = 32,
    localparam int SW    = $clog2(NSLOT),
    localparam int WW    = $clog2(NWORD),
    localparam int CW    = $clog2(NWORD + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [SW-1:0] w_slot,
    input  logic [WW-1:0] w_word,
    input  logic [DW-1:0] w_data,
    input  logic          ce,
    input  logic [SW-1:0] c_slot,
    input  logic [CW-1:0] c_cnt,
    input  logic [SW-1:0] r_slot,
    input  logic [WW-1:0] r_word,
    output logic [DW-1:0] r_data,
    output logic [CW-1:0] r_cnt
);

    localparam int DEPTH = 1 << (SW + WW);
    localparam logic [CW-1:0] MAXC = CW'(NWORD);

    logic [DW-1:0] mem [DEPTH];
    logic [CW-1:0] cnt [NSLOT];

    always_ff @(posedge clk) begin
        if (we) mem[{w_slot, w_word}] <= w_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSLOT; i++) cnt[i] <= '0;
        end else if (ce) begin
            cnt[c_slot] <= (c_cnt > MAXC) ? MAXC : c_cnt;
        end
    end

    always_comb begin
        r_data = mem[{r_slot, r_word}];
        r_cnt  = cnt[r_slot];
    end

    AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        ce |=> (cnt[$past(c_slot)] <= MAXC)); // R2

endmodule

// File: rtl/mbox_rdv.sv
module mbox_rdv
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic fill,
    input  logic drain,
    output logic ack
);

    rdv_st_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= RDV_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RDV_IDLE:   if (load) state_d = RDV_LOADED;
            RDV_LOADED: if (drain) state_d = RDV_ACKED;
            RDV_ACKED: begin
                if (load)      state_d = RDV_LOADED;
                else if (fill) state_d = RDV_IDLE;
            end
            default:    state_d = RDV_IDLE;
        endcase
    end

    always_comb begin
        ack = (state_q == RDV_ACKED);
    end

    AST_ACK_FROM_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> $past(drain)); // R7
    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
        (ack && (fill || load)) |=> !ack); // R7

endmodule

// File: rtl/mbox_shared.sv
module mbox_shared #(
    parameter  int NSLOT   = 8,
    parameter  int NWORD   = 16,
    parameter  int DW      = 32,
    parameter  bit INDEXED = 1'b1,
    localparam int SW      = $clog2(NSLOT),
    localparam int WW      = $clog2(NWORD),
    localparam int CW      = $clog2(NWORD + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SW-1:0]    wr_slot,
    input  logic [WW-1:0]    wr_word,
    input  logic [DW-1:0]    wr_data,
    input  logic             commit,
    input  logic [SW-1:0]    commit_slot,
    input  logic [CW-1:0]    commit_cnt,
    input  logic             rel_en,
    input  logic [SW-1:0]    rel_slot,
    input  logic [SW-1:0]    rd_slot,
    input  logic [WW-1:0]    rd_word,
    output logic [DW-1:0]    rd_data,
    output logic [CW-1:0]    rd_cnt,
    output logic [NSLOT-1:0] slot_ready,
    input  logic [NSLOT-1:0] int_mask,
    output logic             irq,
    output logic             ack,
    output logic             err_ovf,
    output logic             err_unf
);

    logic [SW-1:0]    ws_e, cs_e, rs_e, rd_e;
    logic [NSLOT-1:0] held;
    logic             wr_acc, cm_acc, rl_acc;
    logic             ovf_hit, unf_hit;

    // Slot index folding: rendezvous mode uses slot 0 only
    generate
        if (INDEXED) begin : g_idx
            assign ws_e = wr_slot;
            assign cs_e = commit_slot;
            assign rs_e = rel_slot;
            assign rd_e = rd_slot;
        end else begin : g_rdv_idx
            logic unused_idx;
            assign unused_idx = ^{wr_slot, commit_slot, rel_slot, rd_slot};
            assign ws_e = '0;
            assign cs_e = '0;
            assign rs_e = '0;
            assign rd_e = '0;
        end
    endgenerate

    always_comb begin
        wr_acc  = wr_en  && !held[ws_e];
        cm_acc  = commit && !held[cs_e];
        rl_acc  = rel_en &&  held[rs_e];
        ovf_hit = (wr_en && held[ws_e]) || (commit && held[cs_e]);
        unf_hit = rel_en && !held[rs_e];
    end

    // One semaphore machine per slot
    generate
        for (genvar i = 0; i < NSLOT; i++) begin : g_slot
            mbox_slot u_slot (
                .clk  (clk),
                .rst  (rst),
                .take (cm_acc && (cs_e == SW'(i))),
                .give (rl_acc && (rs_e == SW'(i))),
                .held (held[i])
            );
        end
    endgenerate

    mbox_store #(
        .NSLOT (NSLOT),
        .NWORD (NWORD),
        .DW    (DW)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .we     (wr_acc),
        .w_slot (ws_e),
        .w_word (wr_word),
        .w_data (wr_data),
        .ce     (cm_acc),
        .c_slot (cs_e),
        .c_cnt  (commit_cnt),
        .r_slot (rd_e),
        .r_word (rd_word),
        .r_data (rd_data),
        .r_cnt  (rd_cnt)
    );

    generate
        if (INDEXED) begin : g_noack
            assign ack = 1'b0;
        end else begin : g_ack
            mbox_rdv u_rdv (
                .clk   (clk),
                .rst   (rst),
                .load  (cm_acc),
                .fill  (wr_acc),
                .drain (rl_acc),
                .ack   (ack)
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            err_ovf <= 1'b0;
            err_unf <= 1'b0;
        end else begin
            if (ovf_hit) err_ovf <= 1'b1;
            if (unf_hit) err_unf <= 1'b1;
        end
    end

    always_comb begin
        slot_ready = held;
        irq        = |(held & ~int_mask);
    end

    AST_COMMIT_SETS: assert property (@(posedge clk) disable iff (rst)
        cm_acc |=> held[$past(cs_e)]); // R2
    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        rl_acc |=> !held[$past(rs_e)]); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (wr_en && held[ws_e]) |=> err_ovf); // R3
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_ovf |=> err_ovf); // R3
    AST_UNF_ON_FREE: assert property (@(posedge clk) disable iff (rst)
        (rel_en && !held[rs_e]) |=> err_unf); // R4
    AST_IRQ_NEEDS_HELD: assert property (@(posedge clk) disable iff (rst)
        irq |-> (slot_ready != '0)); // R6
    AST_RDV_ONE_SLOT: assert property (@(posedge clk) disable iff (rst)
        (INDEXED || ($countones(slot_ready) <= 1))); // R7

endmodule

// File: tb/sim_mbox_shared.sv
`timescale 1ns/1ps
module sim_mbox_shared;

    localparam int NS = 8;
    localparam int NW = 16;
    localparam int DW = 32;

    typedef struct packed {
        logic [2:0]    s;
        logic [3:0]    w;
        logic [DW-1:0] d;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    // Indexed instance signals
    logic          a_wr_en = 0, a_commit = 0, a_rel_en = 0;
    logic [2:0]    a_wr_slot = 0, a_commit_slot = 0, a_rel_slot = 0, a_rd_slot = 0;
    logic [3:0]    a_wr_word = 0, a_rd_word = 0;
    logic [DW-1:0] a_wr_data = 0, a_rd_data;
    logic [4:0]    a_commit_cnt = 0, a_rd_cnt;
    logic [NS-1:0] a_mask = 0, a_ready;
    logic          a_irq, a_ack, a_ovf, a_unf;

    // Rendezvous instance signals
    logic          b_wr_en = 0, b_commit = 0, b_rel_en = 0;
    logic [2:0]    b_wr_slot = 0, b_commit_slot = 0, b_rel_slot = 0, b_rd_slot = 0;
    logic [3:0]    b_wr_word = 0, b_rd_word = 0;
    logic [DW-1:0] b_wr_data = 0, b_rd_data;
    logic [4:0]    b_commit_cnt = 0, b_rd_cnt;
    logic [NS-1:0] b_ready;
    logic          b_irq, b_ack, b_ovf, b_unf;

    mbox_shared #(.NSLOT(NS), .NWORD(NW), .DW(DW), .INDEXED(1'b1)) u0 (
        .clk(clk), .rst(rst), .wr_en(a_wr_en), .wr_slot(a_wr_slot),
        .wr_word(a_wr_word), .wr_data(a_wr_data), .commit(a_commit),
        .commit_slot(a_commit_slot), .commit_cnt(a_commit_cnt),
        .rel_en(a_rel_en), .rel_slot(a_rel_slot), .rd_slot(a_rd_slot),
        .rd_word(a_rd_word), .rd_data(a_rd_data), .rd_cnt(a_rd_cnt),
        .slot_ready(a_ready), .int_mask(a_mask), .irq(a_irq), .ack(a_ack),
        .err_ovf(a_ovf), .err_unf(a_unf));

    mbox_shared #(.NSLOT(NS), .NWORD(NW), .DW(DW), .INDEXED(1'b0)) u1 (
        .clk(clk), .rst(rst), .wr_en(b_wr_en), .wr_slot(b_wr_slot),
        .wr_word(b_wr_word), .wr_data(b_wr_data), .commit(b_commit),
        .commit_slot(b_commit_slot), .commit_cnt(b_commit_cnt),
        .rel_en(b_rel_en), .rel_slot(b_rel_slot), .rd_slot(b_rd_slot),
        .rd_word(b_rd_word), .rd_data(b_rd_data), .rd_cnt(b_rd_cnt),
        .slot_ready(b_ready), .int_mask('0), .irq(b_irq), .ack(b_ack),
        .err_ovf(b_ovf), .err_unf(b_unf));

    int    n_chk  = 0;
    int    n_fail = 0;
    item_t exp_q[$];

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(int s, int w, int seed);
        return (DW'(s) << 24) | (DW'(w) << 16) | DW'(seed & 16'hFFFF);
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Driver: writes n words into slot s, commits with cnt, queues expectations
    task automatic produce(int s, int n, int cnt, int seed, bit push);
        for (int w = 0; w < n; w++) begin
            @(negedge clk);
            a_wr_en = 1'b1; a_wr_slot = 3'(s); a_wr_word = 4'(w);
            a_wr_data = pat(s, w, seed);
            if (push) exp_q.push_back('{3'(s), 4'(w), pat(s, w, seed)});
        end
        @(negedge clk);
        a_wr_en = 1'b0;
        a_commit = 1'b1; a_commit_slot = 3'(s); a_commit_cnt = 5'(cnt);
        @(negedge clk);
        a_commit = 1'b0;
    endtask

    // Monitor: pops every queued word of slot s, compares, then releases s
    task automatic consume(int s);
        int i = 0;
        while (i < exp_q.size()) begin
            if (exp_q[i].s == 3'(s)) begin
                a_rd_slot = exp_q[i].s; a_rd_word = exp_q[i].w;
                #1;
                check("R5/R8 read word", a_rd_data, exp_q[i].d);
                exp_q.delete(i);
            end else begin
                i++;
            end
        end
        @(negedge clk);
        a_rel_en = 1'b1; a_rel_slot = 3'(s);
        @(negedge clk);
        a_rel_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 ready", DW'(a_ready), 0);
        check("R1 irq/ack/errors", {a_irq, a_ack, a_ovf, a_unf}, 0);
        check("R1 rdv ack/ready", {b_ack, b_ready}, 0);

        // R2 commit sets ready, count latched
        produce(3, 4, 4, 16'h1111, 1);
        check("R2 ready after commit", DW'(a_ready), 32'h08);
        a_rd_slot = 3; #1;
        check("R2 count", DW'(a_rd_cnt), 4);

        // R5 several slots held
        produce(5, 16, 16, 16'h5555, 1);
        produce(1, 2, 20, 16'h2222, 1);
        check("R5 three held", DW'(a_ready), 32'h2A);
        a_rd_slot = 1; #1;
        check("R2 count clamp", DW'(a_rd_cnt), 16);

        // R6 interrupt masking
        check("R6 irq unmasked", DW'(a_irq), 1);
        a_mask = 8'h2A; #1;
        check("R6 irq all masked", DW'(a_irq), 0);
        a_mask = 8'h0A; #1;
        check("R6 irq slot5 open", DW'(a_irq), 1);
        a_mask = 8'h00;

        // R3 write and commit to held slot rejected
        check("R3 ovf before", DW'(a_ovf), 0);
        produce(3, 1, 9, 16'hDEAD, 0);
        a_rd_slot = 3; a_rd_word = 0; #1;
        check("R3 data kept", a_rd_data, pat(3, 0, 16'h1111));
        check("R3 count kept", DW'(a_rd_cnt), 4);
        check("R3 ovf set", DW'(a_ovf), 1);

        // R5 out-of-order drain, R4 release clears
        consume(5);
        check("R4 slot5 cleared", DW'(a_ready), 32'h0A);
        consume(1);
        check("R4 slot1 cleared", DW'(a_ready), 32'h08);
        consume(3);
        check("R4 all free", DW'(a_ready), 0);
        check("R6 irq idle", DW'(a_irq), 0);
        check("R3 ovf sticky", DW'(a_ovf), 1);

        // R4 release of a free slot
        check("R4 unf before", DW'(a_unf), 0);
        @(negedge clk); a_rel_en = 1'b1; a_rel_slot = 3;
        @(negedge clk); a_rel_en = 1'b0;
        check("R4 unf set", DW'(a_unf), 1);
        check("R4 ready unchanged", DW'(a_ready), 0);

        // R1 reset clears flags
        do_reset(); #1;
        check("R1 errors cleared", {a_ovf, a_unf}, 0);

        // R9 commit and release collide on a held slot
        produce(2, 1, 1, 16'h7777, 0);
        check("R9 held first", DW'(a_ready), 32'h04);
        @(negedge clk);
        a_commit = 1'b1; a_commit_slot = 2; a_commit_cnt = 1;
        a_rel_en = 1'b1; a_rel_slot = 2;
        @(negedge clk);
        a_commit = 1'b0; a_rel_en = 1'b0;
        check("R9 release wins", DW'(a_ready), 0);
        check("R9 ovf set", DW'(a_ovf), 1);

        // R7 rendezvous instance
        @(negedge clk);
        b_wr_en = 1'b1; b_wr_slot = 6; b_wr_word = 0; b_wr_data = 32'hCAFE0001;
        @(negedge clk);
        b_wr_en = 1'b0; b_commit = 1'b1; b_commit_slot = 6; b_commit_cnt = 1;
        @(negedge clk);
        b_commit = 1'b0;
        check("R7 folded to slot0", DW'(b_ready), 32'h01);
        check("R7 no ack yet", DW'(b_ack), 0);
        b_rd_slot = 4; b_rd_word = 0; #1;
        check("R7 read folded", b_rd_data, 32'hCAFE0001);
        @(negedge clk);
        b_wr_en = 1'b1; b_wr_slot = 0; b_wr_word = 0; b_wr_data = 32'hBAD0BAD0;
        @(negedge clk);
        b_wr_en = 1'b0;
        check("R7 write held rejected", b_rd_data, 32'hCAFE0001);
        check("R7 ovf", DW'(b_ovf), 1);
        @(negedge clk);
        b_rel_en = 1'b1; b_rel_slot = 2;
        @(negedge clk);
        b_rel_en = 1'b0;
        check("R7 ack raised", DW'(b_ack), 1);
        check("R7 slot free", DW'(b_ready), 0);
        @(negedge clk);
        b_wr_en = 1'b1; b_wr_slot = 5; b_wr_word = 1; b_wr_data = 32'h00000022;
        @(negedge clk);
        b_wr_en = 1'b0;
        check("R7 ack dropped", DW'(b_ack), 0);
        b_rd_word = 1; #1;
        check("R7 next write stored", b_rd_data, 32'h00000022);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1-all actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule